// File: doc/BRIEF.md
# Configuration Access Route Selector

This block sits in the configuration path of a PCIe root port. Each outgoing configuration access names a target bus, device, function and register. The block decides where that access goes: to the root port's own configuration space (local), onto the link as a Type 0 request, or onto the link as a Type 1 request. The result is registered and leaves one cycle after the access is accepted. It carries a two-bit route code and passes the target fields through unchanged.

Two programmable words drive the decision. The identity word holds the port's local bus number and local device number. The control word holds a secondary bus number and an enable bit for secondary-bus mode.

When the enable bit is clear, the primary and secondary buses share one number. The local device number alone then separates the root port from devices on the link. When the enable bit is set, the block acts like a standard bridge with separate primary and secondary numbers. A build parameter removes the secondary-bus mode for older variants.

Requests use a valid/ready handshake, and so do results. A result that is not taken is held unchanged. While a result is held, `req_ready` stays low, so no new request enters and none is lost. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its result is being taken in the same cycle.

Top module: `cfgsel_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, and both register words read back as 0. In particular, the secondary-bus enable is clear.
- R2: With the enable clear, a target bus equal to the local bus and a target device equal to the local device gives route code 2'b00 (local).
- R3: With the enable clear, a target bus equal to the local bus and a different target device gives route code 2'b01 (Type 0).
- R4: With the enable clear, a target bus different from the local bus gives route code 2'b10 (Type 1), whatever the device.
- R5: With the enable set, a target on the primary bus (the local bus number) at the local device gives 2'b00. A primary-bus target at any other device gives 2'b11 (unsupported).
- R6: With the enable set, a target bus equal to the secondary bus (and not the primary) gives 2'b01. Any other bus gives 2'b10.
- R7: Register writes honour byte enables, one enable bit per byte lane:

  | Word | Select | Field | Bits | Lane enable |
  |---|---|---|---|---|
  | Identity | `reg_sel`=0 | Local bus | [15:8] | `reg_be[1]` |
  | Identity | `reg_sel`=0 | Local device | [20:16] | `reg_be[2]` |
  | Control | `reg_sel`=1 | Secondary bus | [7:0] | `reg_be[0]` |
  | Control | `reg_sel`=1 | Enable | [16] | `reg_be[2]` |

  A write whose enables do not cover a field leaves that field unchanged.
- R8: `reg_rdata` shows the current field values of the word chosen by `reg_sel`, at the positions in R7. All other bits read 0.
- R9: A result appears on the edge after acceptance, with `rsp_valid` high. It carries the route code and the request's bus, device, function and register fields unchanged.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the result holds stable and `req_ready` is low.
- R11: With `HAS_SEC_MODE`=0, the control word reads 0 and cannot be written, and only the rules of R2 to R4 apply.
- R12: A request accepted in the same cycle as a register write is decided with the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 identity, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read-back of the selected word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | REG_W | Target register offset |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken when high with valid |
| rsp_route | output | 2 | Route code: 00 local, 01 Type 0, 10 Type 1, 11 unsupported |
| rsp_bus | output | 8 | Passed-through bus |
| rsp_dev | output | 5 | Passed-through device |
| rsp_fn | output | 3 | Passed-through function |
| rsp_reg | output | REG_W | Passed-through register offset |

## Verification
The assertions watch four behaviours on every cycle.
- A local route always matches the programmed bus and device.
- The unsupported code never appears while the enable is clear.
- A held result stays stable under back-pressure, and an accepted request always produces a result.
- A write without the right lane enable leaves the local bus field alone.

Only the bench scenarios can show the rest. These are the route codes expected for specific bus and device patterns in each mode, the read-back layout, and the legacy build ignoring the enable. They also cover a request that races a register write and is decided on the old values.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int WORD_W = 32;
  localparam int BE_W  = WORD_W / 8;

  typedef enum logic [1:0] {
    ROUTE_LOCAL = 2'b00,
    ROUTE_T0    = 2'b01,
    ROUTE_T1    = 2'b10,
    ROUTE_UNSUP = 2'b11
  } route_e;
endpackage

// File: rtl/cfgsel_regs.sv
module cfgsel_regs
  import cfgsel_pkg::*;
#(
  parameter bit HAS_SEC_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic [WORD_W-1:0] rdata,
  output logic [BUS_W-1:0]  loc_bus,
  output logic [DEV_W-1:0]  loc_dev,
  output logic [BUS_W-1:0]  sec_bus,
  output logic              sec_en
);
  localparam int BUS_LSB = 8;
  localparam int DEV_LSB = 16;
  localparam int EN_BIT  = 16;

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_bus <= '0;
      loc_dev <= '0;
    end else if (we && !sel) begin
      if (be[1]) loc_bus <= wdata[BUS_LSB +: BUS_W];
      if (be[2]) loc_dev <= wdata[DEV_LSB +: DEV_W];
    end
  end

  generate
    if (HAS_SEC_MODE) begin : g_sec
      logic [BUS_W-1:0] sec_bus_q;
      logic             sec_en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sec_bus_q <= '0;
          sec_en_q  <= 1'b0;
        end else if (we && sel) begin
          if (be[0]) sec_bus_q <= wdata[0 +: BUS_W];
          if (be[2]) sec_en_q  <= wdata[EN_BIT];
        end
      end
      assign sec_bus = sec_bus_q;
      assign sec_en  = sec_en_q;
    end else begin : g_nosec
      assign sec_bus = '0;
      assign sec_en  = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata[BUS_LSB +: BUS_W] = loc_bus;
      rdata[DEV_LSB +: DEV_W] = loc_dev;
    end else begin
      rdata[0 +: BUS_W] = sec_bus;
      rdata[EN_BIT]     = sec_en;
    end
  end

  // R7: local bus field untouched unless its lane is enabled
  assert_bus_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (!be[1] || sel)) |=> $stable(loc_bus));
endmodule

// File: rtl/cfgsel_decode.sv
module cfgsel_decode
  import cfgsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [BUS_W-1:0] loc_bus,
  input  logic [DEV_W-1:0] loc_dev,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic             sec_en,
  output route_e           route
);
  logic on_primary, is_local_dev;
  assign on_primary   = (bus == loc_bus);
  assign is_local_dev = (dev == loc_dev);

  always_comb begin
    if (on_primary) begin
      if (is_local_dev)      route = ROUTE_LOCAL;
      else if (sec_en)       route = ROUTE_UNSUP;
      else                   route = ROUTE_T0;
    end else if (sec_en && bus == sec_bus) begin
      route = ROUTE_T0;
    end else begin
      route = ROUTE_T1;
    end
  end

  // R2, R5: local route only for the programmed bus and device
  assert_local_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_LOCAL) |-> (bus == loc_bus && dev == loc_dev));
  // R3: unsupported code only exists in secondary-bus mode
  assert_no_unsup_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> (route != ROUTE_UNSUP));
endmodule

// File: rtl/cfgsel_outreg.sv
module cfgsel_outreg
  import cfgsel_pkg::*;
#(
  parameter int REG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  route_e           in_route,
  input  logic [BUS_W-1:0] in_bus,
  input  logic [DEV_W-1:0] in_dev,
  input  logic [FN_W-1:0]  in_fn,
  input  logic [REG_W-1:0] in_reg,
  output logic             out_valid,
  input  logic             out_ready,
  output route_e           out_route,
  output logic [BUS_W-1:0] out_bus,
  output logic [DEV_W-1:0] out_dev,
  output logic [FN_W-1:0]  out_fn,
  output logic [REG_W-1:0] out_reg
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_route <= ROUTE_LOCAL;
      out_bus   <= '0;
      out_dev   <= '0;
      out_fn    <= '0;
      out_reg   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_route <= in_route;
        out_bus   <= in_bus;
        out_dev   <= in_dev;
        out_fn    <= in_fn;
        out_reg   <= in_reg;
      end
    end
  end

  // R9: accepted request yields a result on the next edge
  assert_accept_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R10: held result stays stable under back-pressure
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_route) &&
      $stable(out_bus) && $stable(out_dev) && $stable(out_fn) && $stable(out_reg)));
endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top
  import cfgsel_pkg::*;
#(
  parameter int REG_W        = 10,
  parameter bit HAS_SEC_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_fn,
  input  logic [REG_W-1:0]  req_reg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_route,
  output logic [7:0]        rsp_bus,
  output logic [4:0]        rsp_dev,
  output logic [2:0]        rsp_fn,
  output logic [REG_W-1:0]  rsp_reg
);
  logic [BUS_W-1:0] loc_bus, sec_bus;
  logic [DEV_W-1:0] loc_dev;
  logic             sec_en;
  route_e           dec_route, out_route;

  cfgsel_regs #(.HAS_SEC_MODE(HAS_SEC_MODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
    .loc_bus(loc_bus), .loc_dev(loc_dev), .sec_bus(sec_bus), .sec_en(sec_en)
  );

  cfgsel_decode u_dec (
    .clk(clk), .rst_n(rst_n), .bus(req_bus), .dev(req_dev),
    .loc_bus(loc_bus), .loc_dev(loc_dev), .sec_bus(sec_bus), .sec_en(sec_en),
    .route(dec_route)
  );

  cfgsel_outreg #(.REG_W(REG_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_route(dec_route),
    .in_bus(req_bus), .in_dev(req_dev), .in_fn(req_fn), .in_reg(req_reg),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_route(out_route),
    .out_bus(rsp_bus), .out_dev(rsp_dev), .out_fn(rsp_fn), .out_reg(rsp_reg)
  );

  assign rsp_route = out_route;
endmodule

// File: tb/sim_cfgsel_top.sv
module sim_cfgsel_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = '0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_fn = '0;
  logic [9:0] req_reg = '0;

  logic [31:0] rd0, rd1;
  logic rdy0, rdy1, v0, v1;
  logic [1:0] rt0, rt1;
  logic [7:0] b0, b1;
  logic [4:0] d0, d1;
  logic [2:0] f0, f1;
  logic [9:0] g0, g1;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cfgsel_top #(.REG_W(10), .HAS_SEC_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(rd0),
    .req_valid(req_valid), .req_ready(rdy0), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .rsp_valid(v0), .rsp_ready(rsp_ready), .rsp_route(rt0),
    .rsp_bus(b0), .rsp_dev(d0), .rsp_fn(f0), .rsp_reg(g0));

  cfgsel_top #(.REG_W(10), .HAS_SEC_MODE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(rd1),
    .req_valid(req_valid), .req_ready(rdy1), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .rsp_valid(v1), .rsp_ready(rsp_ready), .rsp_route(rt1),
    .rsp_bus(b1), .rsp_dev(d1), .rsp_fn(f1), .rsp_reg(g1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data; reg_be = be;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    reg_sel = sel;
    #1;
    a = rd0; b = rd1;
  endtask

  // one request, checks both instances one cycle later
  task automatic send(input string req, input logic [7:0] bus, input logic [4:0] dev,
                      input logic [1:0] exp0, input logic [1:0] exp1);
    @(negedge clk);
    req_valid = 1'b1; req_bus = bus; req_dev = dev;
    req_fn = dev[2:0] ^ 3'd5; req_reg = {bus[1:0], 8'hA5} ^ {5'd0, dev};
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {30'd0, v1, v0}, 32'd3);
    check({req, " route u0"}, {30'd0, rt0}, {30'd0, exp0});
    check({req, " route u1"}, {30'd0, rt1}, {30'd0, exp1});
    check("R9 passthrough", {b0, d0, f0, g0}, {bus, dev, dev[2:0] ^ 3'd5,
          {bus[1:0], 8'hA5} ^ {5'd0, dev}});
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    check("R1 rsp_valid after reset", {31'd0, v0}, 32'd0);
    rd(1'b0, a, b); check("R1 identity word", a, 32'd0);
    rd(1'b1, a, b); check("R1 control word", a, 32'd0);
  endtask

  task automatic t_shared();
    wr(1'b0, 32'h0000_0500, 4'b0110);   // local bus 5, local dev 0
    send("R2 local", 8'd5, 5'd0, 2'b00, 2'b00);
    send("R3 type0", 8'd5, 5'd3, 2'b01, 2'b01);
    send("R4 type1", 8'd6, 5'd0, 2'b10, 2'b10);
    send("R4 type1 bus0", 8'd0, 5'd0, 2'b10, 2'b10);
  endtask

  task automatic t_lanes();
    logic [31:0] a, b;
    wr(1'b0, 32'h0002_7700, 4'b0100);   // only device lane
    rd(1'b0, a, b);
    check("R7 bus kept, dev written", a, 32'h0002_0500);
    check("R8 identity layout", b, 32'h0002_0500);
    wr(1'b0, 32'h0000_0000, 4'b1001);   // lanes that hold no identity field
    rd(1'b0, a, b);
    check("R7 unrelated lanes ignored", a, 32'h0002_0500);
    wr(1'b0, 32'h0000_0500, 4'b0110);
  endtask

  task automatic t_secmode();
    logic [31:0] a, b;
    wr(1'b1, 32'h0001_0009, 4'b0101);   // secondary bus 9, enable
    rd(1'b1, a, b);
    check("R8 control layout", a, 32'h0001_0009);
    check("R11 legacy control reads 0", b, 32'h0);
    send("R5 primary local", 8'd5, 5'd0, 2'b00, 2'b00);
    send("R5 primary other dev / R11", 8'd5, 5'd4, 2'b11, 2'b01);
    send("R6 secondary / R11", 8'd9, 5'd1, 2'b01, 2'b10);
    send("R6 other bus", 8'd12, 5'd0, 2'b10, 2'b10);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_bus = 8'd9; req_dev = 5'd2;
    req_fn = 3'd1; req_reg = 10'd3;
    @(negedge clk);
    req_bus = 8'd20; req_dev = 5'd7; req_fn = 3'd6; req_reg = 10'd44;
    check("R10 ready low while held", {31'd0, rdy0}, 32'd0);
    check("R10 first result", {22'd0, rt0, b0}, {22'd0, 2'b01, 8'd9});
    @(negedge clk);
    check("R10 result held", {14'd0, rt0, b0, d0, f0}, {14'd0, 2'b01, 8'd9, 5'd2, 3'd1});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second result after release", {14'd0, rt0, b0, d0, f0},
          {14'd0, 2'b10, 8'd20, 5'd7, 3'd6});
    check("R9 second reg passthrough", {22'd0, g0}, 32'd44);
  endtask

  task automatic t_race();
    @(negedge clk);
    req_valid = 1'b1; req_bus = 8'd9; req_dev = 5'd0; req_fn = 3'd0; req_reg = 10'd0;
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_0000; reg_be = 4'b0100;
    @(negedge clk);
    req_valid = 1'b0; reg_we = 1'b0; reg_be = '0;
    check("R12 decided on old enable", {30'd0, rt0}, 32'd1);
    send("R12 after write shared rules", 8'd9, 5'd0, 2'b10, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_lanes();
    t_secmode();
    t_backpressure();
    t_race();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule